// File: doc/BRIEF.md
# Per-Packet Reseeded Data Scrambler

This block whitens payload bits before they are encoded for transmission. Each incoming bit is XORed with one bit of a pseudo-random keystream drawn from a seven-stage linear feedback shift register with polynomial x^7 + x^4 + 1. The one-bit recurrence is unrolled in hardware, so a word of W bits (W set by parameter) is scrambled in every clock. The output bits are the same as a serial scrambler running one bit per clock would produce.

Words arrive on a valid/ready handshake together with a start-of-packet flag. A word that carries the flag is scrambled from a fixed nonzero seed, so every packet begins from the same keystream, whatever the previous packet left in the register. The register moves forward only when a word is actually transferred. Scrambled words leave through one output register on a matching valid/ready handshake, and the start-of-packet flag travels with them.

Top module: `pkt_scrambler`

## Requirements
- R1: During and after reset, outValid is 0 and inReady is 1. The keystream register holds the seed (default 7'b1011101), so a first word sent without the start flag is scrambled from the seed.
- R2: The keystream follows this serial step from state s[6:0]: key = s[6] XOR s[3], then the next state is {s[5:0], key}. Output bit i of a word equals input bit i XOR the i-th key bit. Bit 0 is the earliest bit in serial order, and the register state is never all zeros.
- R3: A transferred word with inSop=1 is scrambled starting from the seed state, not from the state the previous packet left.
- R4: The keystream register advances by exactly W steps on each input transfer (inValid and inReady both 1). It does not move in any other cycle, including stalls. inSop on a word that is not transferred has no effect.
- R5: inReady is 1 exactly when outValid is 0 or outReady is 1. While outValid=1 and outReady=0, outData and outSop hold their values.
- R6: A word accepted at a clock edge is presented after that edge with outValid=1 and outSop equal to its inSop. outValid falls after an output transfer that has no new input with it.
- R7: A word without inSop continues the keystream from exactly where the previous transferred word stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is valid |
| inReady | output | 1 | Block can take an input word |
| inData | input | W | Plain payload bits, bit 0 earliest |
| inSop | input | 1 | Word is the first of a packet |
| outValid | output | 1 | Output word is valid |
| outReady | input | 1 | Downstream takes the output word |
| outData | output | W | Scrambled payload bits |
| outSop | output | 1 | Start flag of the output word |

## Verification
The checker assumes that inValid, inData and inSop change only between clock edges. It also assumes that the keystream state it observes is the one the datapath exposes. It does not assume that the sender holds a word once it has offered it. For that reason, the bench sometimes changes or withdraws an offered word during a stall, and it raises inSop on words that are refused. This shows that only transferred words move the keystream or reload it. The bench drives every input half a cycle away from the active edge. It mixes continuous streaming, random backpressure and back-to-back packet starts.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int LFSR_LEN = 7;
  localparam int TAP_HI   = 6;
  localparam int TAP_LO   = 3;

  typedef struct packed {
    logic advance;
    logic loadSeed;
    logic capture;
  } scrCtl_t;
endpackage

// File: rtl/scr_control.sv
module scr_control
  import scr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inSop,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output scrCtl_t ctl
);
  logic outValidQ;
  logic accept;

  assign inReady = !outValidQ || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    ctl.advance  = accept;
    ctl.capture  = accept;
    ctl.loadSeed = inSop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
    end else if (accept) begin
      outValidQ <= 1'b1;
    end else if (outReady) begin
      outValidQ <= 1'b0;
    end
  end

  assign outValid = outValidQ;
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [LFSR_LEN-1:0] SEED = 7'b1011101
)(
  input  logic                clk,
  input  logic                rstN,
  input  scrCtl_t             ctl,
  input  logic [W-1:0]        inData,
  input  logic                inSop,
  output logic [W-1:0]        outData,
  output logic                outSop,
  output logic [LFSR_LEN-1:0] lfsrState
);
  logic [LFSR_LEN-1:0] lfsrQ;
  logic [LFSR_LEN-1:0] chain [W+1];
  logic [W-1:0]        keyBits;
  logic [W-1:0]        outDataQ;
  logic                outSopQ;

  assign chain[0] = ctl.loadSeed ? SEED : lfsrQ;

  for (genvar i = 0; i < W; i++) begin : g_step
    assign keyBits[i]  = chain[i][TAP_HI] ^ chain[i][TAP_LO];
    assign chain[i+1]  = {chain[i][LFSR_LEN-2:0], keyBits[i]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ    <= SEED;
      outDataQ <= '0;
      outSopQ  <= 1'b0;
    end else begin
      if (ctl.advance) lfsrQ <= chain[W];
      if (ctl.capture) begin
        outDataQ <= inData ^ keyBits;
        outSopQ  <= inSop;
      end
    end
  end

  assign outData   = outDataQ;
  assign outSop    = outSopQ;
  assign lfsrState = lfsrQ;
endmodule

// File: rtl/pkt_scrambler.sv
module pkt_scrambler
  import scr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [LFSR_LEN-1:0] SEED = 7'b1011101
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] inData,
  input  logic         inSop,
  output logic         outValid,
  input  logic         outReady,
  output logic [W-1:0] outData,
  output logic         outSop
);
  scrCtl_t             ctl;
  logic [LFSR_LEN-1:0] lfsrState;

  scr_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  scr_datapath #(.W(W), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inSop(inSop),
    .outData(outData), .outSop(outSop), .lfsrState(lfsrState)
  );
endmodule

// File: rtl/pkt_scrambler_chk.sv
module pkt_scrambler_chk #(
  parameter int W = 8
)(
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic         inSop,
  input logic         outValid,
  input logic         outReady,
  input logic [W-1:0] outData,
  input logic         outSop,
  input logic [6:0]   lfsrState
);
  // R5: a stalled output holds its word
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop));

  // R4: the keystream state moves only on an input transfer
  assert_no_stall_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> $stable(lfsrState));

  // R6: an accepted word shows up with its start flag
  assert_present_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid && (outSop == $past(inSop)));

  // R6: a drained output without new input goes idle
  assert_drain_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !inValid |=> !outValid);

  // R2: the keystream register never locks up at zero
  assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != 7'd0);
endmodule

bind pkt_scrambler pkt_scrambler_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSop(inSop),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outSop(outSop),
  .lfsrState(lfsrState)
);

// File: tb/pkt_scrambler_tb.sv
module pkt_scrambler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [6:0] SEED = 7'b1011101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSop = 1'b0, outReady = 1'b0;
  logic [W-1:0] inData = '0;
  logic inReady, outValid, outSop;
  logic [W-1:0] outData;

  pkt_scrambler #(.W(W), .SEED(SEED)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSop(inSop), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSop(outSop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int modSt;
  logic [W-1:0] expData[$];
  logic         expSop[$];
  string        expTag[$];
  string        phaseTag = "R1";
  bit           holdPending = 0;
  logic [W-1:0] holdData;
  logic         holdSop;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial keystream model, one bit at a time, bit 0 earliest
  function automatic logic [W-1:0] modelWord(logic [W-1:0] d, logic s);
    logic [W-1:0] r;
    if (s) modSt = SEED;
    for (int i = 0; i < W; i++) begin
      int fb;
      fb = ((modSt >> 6) ^ (modSt >> 3)) & 1;
      r[i] = d[i] ^ fb[0];
      modSt = ((modSt << 1) | fb) & 127;
    end
    return r;
  endfunction

  task automatic step(bit v, logic [W-1:0] d, bit s, bit r);
    bit expValid, expReady;
    @(negedge clk);
    inValid = v; inData = d; inSop = s; outReady = r;
    #1;
    expValid = (expData.size() != 0);
    expReady = !expValid || r;
    check(outValid == expValid, "R6 outValid", outValid, expValid);
    check(inReady == expReady, "R5 inReady", inReady, expReady);
    if (holdPending) begin
      check(outData == holdData && outSop == holdSop, "R5 hold", outData, holdData);
    end
    holdPending = expValid && !r;
    holdData = outData; holdSop = outSop;
    if (expValid && r) begin
      logic [W-1:0] ed; logic es; string et;
      ed = expData.pop_front(); es = expSop.pop_front(); et = expTag.pop_front();
      check(outData == ed, et, outData, ed);
      check(outSop == es, "R6 outSop", outSop, es);
    end
    if (v && expReady) begin
      expData.push_back(modelWord(d, s));
      expSop.push_back(s);
      expTag.push_back(s ? "R3" : phaseTag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    modSt = SEED;
    repeat (3) @(negedge clk);
    #1;
    check(outValid == 1'b0, "R1 reset outValid", outValid, 0);
    check(inReady == 1'b1, "R1 reset inReady", inReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    // first word without start flag: seed state
    phaseTag = "R1";
    step(1, 8'hA5, 0, 1);
    // continuous stream, keystream continues
    phaseTag = "R7";
    for (int k = 0; k < 20; k++) step(1, W'($urandom), 0, 1);
    // packets of assorted data patterns
    phaseTag = "R2";
    for (int p = 0; p < 6; p++) begin
      step(1, 8'h00, 1, 1);
      for (int k = 0; k < 5 + p; k++) step(1, (p[0] ? 8'hFF : W'($urandom)), 0, 1);
    end
    // back-to-back packet starts
    for (int k = 0; k < 6; k++) step(1, W'($urandom), 1, 1);
    // stalls, idle cycles, and start flags on refused words
    phaseTag = "R4";
    for (int k = 0; k < 400; k++)
      step($urandom_range(0, 1), W'($urandom), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 2) != 0));
    step(1, 8'h3C, 1, 0);
    for (int k = 0; k < 4; k++) step(1, W'($urandom), 1, 0);
    for (int k = 0; k < 3; k++) step(1, W'($urandom), 0, 0);
    step(0, 8'h00, 0, 1);
    step(1, 8'h5A, 0, 1);
    // drain
    for (int k = 0; k < 4; k++) step(0, 8'h00, 0, 1);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule